// File: doc/BRIEF.md
# Keyboard Wake Sequence Matcher

This block listens to the bytes coming out of a keyboard serial receiver and decides when a keystroke pattern should wake the system. Each received scan code comes in as an 8-bit value with a one-cycle valid strobe. Three independent matchers watch that single byte stream at the same time. They are named power, sleep and resume, and each one is programmed with its own sequence of one to eight bytes. When a matcher sees its full sequence, it raises its own wake request. A fourth request, the any-key request, can be enabled so that any received byte raises it.

Every request is a sticky flag. Once set, it stays set until software writes a one to its clear bit. This allows a slow power controller to sample the flags at its own pace. The matchers are programmed through a byte-wide write port that selects a matcher and a sequence position. Each matcher also has a length field, which is the length minus one, and an enable. The block holds no other state.

Top module: `kbd_wake_match`

## Requirements
- R1: After reset all four request flags read 0 and every matcher is at the start of its sequence.
- R2: A matcher sets its request flag on the clock edge that samples the last byte of its sequence, so the flag reads 1 from the next cycle. Request bit 0 is power, bit 1 is sleep and bit 2 is resume.
- R3: A matcher's length is its 3-bit length field plus one, giving 1 to 8 bytes. Stored sequence bytes at positions at or beyond that length have no effect on matching.
- R4: A byte that does not equal the expected byte sends the matcher back to the start. If that byte equals the first byte of the sequence, the matcher continues from the second position instead.
- R5: After a completed match the matcher restarts at position 0. Bytes of the completed match are not reused for a following match.
- R6: While a matcher's enable is 0 it cannot set its flag and its position is held at the start. A partial sequence in progress when it is disabled is lost.
- R7: Writing any byte of a matcher's sequence (select 0 power, 1 sleep, 2 resume; index = position) returns that matcher to the start. A byte arriving in the same cycle is not counted for that matcher.
- R8: Request flags stay set until a 1 is written to the matching bit of the clear input. Clear bits written as 0 leave their flags alone. A request that arrives in the same cycle as its clear leaves the flag set.
- R9: With the any-key enable at 1, every valid byte sets request bit 3. With it at 0, bytes never set bit 3.
- R10: The three matchers work at the same time on the same bytes. Each matcher sets only its own request bit.
- R11: A code presented while the valid strobe is 0 has no effect on any matcher or flag.
- R12: The combined wake output is 1 exactly when at least one request flag is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| kb_vld | input | 1 | One-cycle strobe: a received scan code is present |
| kb_code | input | 8 | Received scan code |
| any_key_en | input | 1 | Any received byte raises request bit 3 |
| match_en | input | 3 | Per-matcher enable, bit 0 power, bit 1 sleep, bit 2 resume |
| match_len_m1 | input | 9 | Per-matcher length minus one, 3 bits each, power in the low bits |
| seq_wr | input | 1 | Write strobe for a sequence byte |
| seq_sel | input | 2 | Matcher selected by the write |
| seq_idx | input | 3 | Sequence position written |
| seq_data | input | 8 | Sequence byte written |
| req_clr | input | 4 | Write-1-to-clear for the four request flags |
| wake_req | output | 4 | Sticky request flags: power, sleep, resume, any-key |
| wake_any | output | 1 | OR of all request flags |

## Verification
The embedded properties check on every cycle the rules that are local to one cycle. A disabled or rewritten matcher returns to the start. A matcher does not move when no byte is present, and it restarts after a hit. The flags follow their set, hold and clear rules, and a request never appears without a valid byte. Only the bench scenarios can show the actual sequence recognition. They also show the fall-back to the second position when a repeated first byte breaks a match, the effect of the programmed length, and the independence of the three matchers on a shared stream. These are checked against hand-computed flag values after each byte.

// File: rtl/kwm_pkg.sv
package kwm_pkg;
   // Matcher channels, also the request bit positions
   localparam int N_MATCH   = 3;
   localparam int CH_POWER  = 0;
   localparam int CH_SLEEP  = 1;
   localparam int CH_RESUME = 2;
   // Any-key request sits above the matcher requests
   localparam int REQ_ANY   = N_MATCH;
   localparam int N_REQ     = N_MATCH + 1;
   localparam int SEL_W     = (N_MATCH > 1) ? $clog2(N_MATCH) : 1;

   function automatic int pos_width(input int max_len);
      return (max_len > 1) ? $clog2(max_len) : 1;
   endfunction
endpackage

// File: rtl/kwm_seq_store.sv
module kwm_seq_store #(
   parameter int CODE_W  = 8,
   parameter int MAX_LEN = 8,
   parameter int IDX_W   = 3
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           wr,
   input  logic [IDX_W-1:0]               widx,
   input  logic [CODE_W-1:0]              wdata,
   output logic [MAX_LEN-1:0][CODE_W-1:0] seq
);
   // One register per sequence position
   for (genvar j = 0; j < MAX_LEN; j++) begin : g_slot
      logic hit_slot;
      assign hit_slot = wr && (widx == IDX_W'(j));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        seq[j] <= '0;
         else if (hit_slot) seq[j] <= wdata;
      end
   end
endmodule

// File: rtl/kwm_seq_match.sv
module kwm_seq_match #(
   parameter int CODE_W  = 8,
   parameter int MAX_LEN = 8,
   parameter int POS_W   = 3
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           en,
   input  logic                           restart,
   input  logic                           vld,
   input  logic [CODE_W-1:0]              code,
   input  logic [POS_W-1:0]               len_m1,
   input  logic [MAX_LEN-1:0][CODE_W-1:0] seq,
   output logic                           hit_o
);
   localparam logic [POS_W-1:0] LAST = POS_W'(MAX_LEN - 1);
   localparam logic [POS_W-1:0] ONE  = POS_W'(1);

   logic [POS_W-1:0]  pos_q, pos_d, eff_pos, len_eff;
   logic [CODE_W-1:0] want;
   logic              at_end, eq_want, eq_first, live;

   always_comb begin
      len_eff  = (len_m1 > LAST) ? LAST : len_m1;
      eff_pos  = (pos_q > len_eff) ? '0 : pos_q;
      want     = seq[eff_pos];
      eq_want  = (code == want);
      eq_first = (code == seq[0]);
      at_end   = (eff_pos == len_eff);
      live     = en && !restart;
      hit_o    = live && vld && eq_want && at_end;
   end

   always_comb begin
      pos_d = pos_q;
      if (!live) begin
         pos_d = '0;
      end else if (vld) begin
         if (eq_want)       pos_d = at_end ? '0 : eff_pos + ONE;
         else if (eq_first) pos_d = ONE;
         else               pos_d = '0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pos_q <= '0;
      else        pos_q <= pos_d;
   end

   AST_DIS_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (pos_q == '0)); // R6
   AST_WR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (pos_q == '0)); // R7
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !restart && !vld) |=> $stable(pos_q)); // R11
   AST_HIT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      hit_o |=> (pos_q == '0)); // R5
endmodule

// File: rtl/kwm_req_flags.sv
module kwm_req_flags #(
   parameter int N = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set,
   input  logic [N-1:0] clr,
   output logic [N-1:0] flag_q
);
   for (genvar i = 0; i < N; i++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      flag_q[i] <= 1'b0;
         else if (set[i]) flag_q[i] <= 1'b1;
         else if (clr[i]) flag_q[i] <= 1'b0;
      end

      AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
         (flag_q[i] && !clr[i]) |=> flag_q[i]); // R8
      AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
         set[i] |=> flag_q[i]); // R8
      AST_NO_SPONT: assert property (@(posedge clk) disable iff (!rst_n)
         (!set[i] && !flag_q[i]) |=> !flag_q[i]); // R8
      AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
         (clr[i] && !set[i]) |=> !flag_q[i]); // R8
   end
endmodule

// File: rtl/kbd_wake_match.sv
module kbd_wake_match
   import kwm_pkg::*;
#(
   parameter int CODE_W  = 8,
   parameter int MAX_LEN = 8,
   localparam int POS_W  = pos_width(MAX_LEN)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     kb_vld,
   input  logic [CODE_W-1:0]        kb_code,
   input  logic                     any_key_en,
   input  logic [N_MATCH-1:0]       match_en,
   input  logic [N_MATCH*POS_W-1:0] match_len_m1,
   input  logic                     seq_wr,
   input  logic [SEL_W-1:0]         seq_sel,
   input  logic [POS_W-1:0]         seq_idx,
   input  logic [CODE_W-1:0]        seq_data,
   input  logic [N_REQ-1:0]         req_clr,
   output logic [N_REQ-1:0]         wake_req,
   output logic                     wake_any
);
   // Elaboration-time parameter checks
   if (CODE_W < 1) begin : g_bad_code_w
      $error("kbd_wake_match: CODE_W must be at least 1");
   end
   if (MAX_LEN < 1) begin : g_bad_max_len
      $error("kbd_wake_match: MAX_LEN must be at least 1");
   end

   logic [N_MATCH-1:0] hit;
   logic [N_REQ-1:0]   req_set;

   for (genvar c = 0; c < N_MATCH; c++) begin : g_ch
      logic                           wr_ch;
      logic [MAX_LEN-1:0][CODE_W-1:0] seq;

      assign wr_ch = seq_wr && (seq_sel == SEL_W'(c));

      kwm_seq_store #(
         .CODE_W (CODE_W),
         .MAX_LEN(MAX_LEN),
         .IDX_W  (POS_W)
      ) i_store (
         .clk  (clk),
         .rst_n(rst_n),
         .wr   (wr_ch),
         .widx (seq_idx),
         .wdata(seq_data),
         .seq  (seq)
      );

      kwm_seq_match #(
         .CODE_W (CODE_W),
         .MAX_LEN(MAX_LEN),
         .POS_W  (POS_W)
      ) i_match (
         .clk    (clk),
         .rst_n  (rst_n),
         .en     (match_en[c]),
         .restart(wr_ch),
         .vld    (kb_vld),
         .code   (kb_code),
         .len_m1 (match_len_m1[c*POS_W +: POS_W]),
         .seq    (seq),
         .hit_o  (hit[c])
      );
   end

   assign req_set = {kb_vld && any_key_en, hit};

   kwm_req_flags #(.N(N_REQ)) i_flags (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (req_set),
      .clr   (req_clr),
      .flag_q(wake_req)
   );

   assign wake_any = |wake_req;

   AST_ANYKEY_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (kb_vld && any_key_en) |=> wake_req[REQ_ANY]); // R9
   AST_NO_REQ_WITHOUT_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
      (!kb_vld && (wake_req == '0)) |=> (wake_req == '0)); // R11
endmodule

// File: tb/test_kbd_wake_match.sv
`timescale 1ns/1ps
module test_kbd_wake_match;
   localparam real CLK_NS = 20.0;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       kb_vld = 1'b0;
   logic [7:0] kb_code = '0;
   logic       any_key_en = 1'b0;
   logic [2:0] match_en = '0;
   logic [8:0] match_len_m1 = '0;
   logic       seq_wr = 1'b0;
   logic [1:0] seq_sel = '0;
   logic [2:0] seq_idx = '0;
   logic [7:0] seq_data = '0;
   logic [3:0] req_clr = '0;
   logic [3:0] wake_req;
   logic       wake_any;

   int checks = 0;
   int errors = 0;

   always #(CLK_NS/2) clk = ~clk;

   kbd_wake_match i_kbd_wake_match (
      .clk(clk), .rst_n(rst_n), .kb_vld(kb_vld), .kb_code(kb_code),
      .any_key_en(any_key_en), .match_en(match_en),
      .match_len_m1(match_len_m1), .seq_wr(seq_wr), .seq_sel(seq_sel),
      .seq_idx(seq_idx), .seq_data(seq_data), .req_clr(req_clr),
      .wake_req(wake_req), .wake_any(wake_any)
   );

   // {code, clear-before, expected flags after the byte}
   // power = 12 34 56 (len 3, slot 3 holds 99), sleep = 12 12, resume = 5A
   localparam logic [15:0] VEC [15] = '{
      16'h1200, 16'h3400, 16'h5601, 16'h1210, 16'h1202,
      16'h1202, 16'h3402, 16'h1202, 16'h3402, 16'h5603,
      16'h5A34, 16'h1204, 16'h1206, 16'h1260, 16'h1202
   };

   task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %b expected %b", tag, act, exp);
      end
   endtask

   task automatic send(input logic [7:0] b);
      @(negedge clk); kb_vld = 1'b1; kb_code = b;
      @(negedge clk); kb_vld = 1'b0;
   endtask

   task automatic clear(input logic [3:0] m);
      @(negedge clk); req_clr = m;
      @(negedge clk); req_clr = '0;
   endtask

   task automatic wseq(input logic [1:0] ch, input logic [2:0] idx, input logic [7:0] d);
      @(negedge clk); seq_wr = 1'b1; seq_sel = ch; seq_idx = idx; seq_data = d;
      @(negedge clk); seq_wr = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 flags after reset", wake_req, 4'b0000);
      check("R12 wake_any after reset", {3'b0, wake_any}, 4'b0000);

      // program: power len 3, sleep len 2, resume len 1
      match_len_m1 = {3'd0, 3'd1, 3'd2};
      wseq(2'd0, 3'd0, 8'h12); wseq(2'd0, 3'd1, 8'h34);
      wseq(2'd0, 3'd2, 8'h56); wseq(2'd0, 3'd3, 8'h99);
      wseq(2'd1, 3'd0, 8'h12); wseq(2'd1, 3'd1, 8'h12);
      wseq(2'd2, 3'd0, 8'h5A);
      match_en = 3'b111;

      for (int v = 0; v < 15; v++) begin
         if (VEC[v][7:4] != 4'h0) clear(VEC[v][7:4]);
         send(VEC[v][15:8]);
         check($sformatf("R2 R3 R4 R5 R10 vector %0d", v), wake_req, VEC[v][3:0]);
      end

      // reset positions of all matchers
      clear(4'hF);
      @(negedge clk); match_en = 3'b000;
      @(negedge clk); match_en = 3'b111;

      // R6: disabling loses the partial sequence
      send(8'h12); send(8'h34);
      @(negedge clk); match_en = 3'b110;
      @(negedge clk); match_en = 3'b111;
      send(8'h56);
      check("R6 partial lost on disable", wake_req, 4'b0000);
      @(negedge clk); match_en = 3'b110;
      send(8'h12); send(8'h34); send(8'h56);
      check("R6 disabled matcher no hit", wake_req, 4'b0000);
      @(negedge clk); match_en = 3'b111;
      send(8'h12); send(8'h34); send(8'h56);
      check("R6 re-enabled matcher hits", wake_req, 4'b0001);
      clear(4'hF);

      // R7: sequence write restarts the matcher
      send(8'h12); send(8'h34);
      wseq(2'd0, 3'd5, 8'h00);
      send(8'h56);
      check("R7 write restarts matcher", wake_req, 4'b0000);

      // R11: code without strobe
      @(negedge clk); kb_code = 8'h5A;
      @(negedge clk); kb_code = 8'h00;
      check("R11 code without valid ignored", wake_req, 4'b0000);

      // R8: set wins over clear, unrelated clears keep flag
      @(negedge clk); kb_vld = 1'b1; kb_code = 8'h5A; req_clr = 4'b0100;
      @(negedge clk); kb_vld = 1'b0; req_clr = '0;
      check("R8 set beats clear", wake_req, 4'b0100);
      clear(4'b1011);
      check("R8 other clears no effect", wake_req, 4'b0100);
      repeat (5) @(negedge clk);
      check("R8 flag sticky", wake_req, 4'b0100);
      clear(4'b0100);
      check("R8 write-1 clears", wake_req, 4'b0000);

      // R9: any-key mode
      @(negedge clk); any_key_en = 1'b1;
      send(8'h00);
      check("R9 any-key sets bit 3", wake_req, 4'b1000);
      check("R12 wake_any set", {3'b0, wake_any}, 4'b0001);
      clear(4'b1000);
      @(negedge clk); any_key_en = 1'b0;
      send(8'h00);
      check("R9 any-key off", wake_req, 4'b0000);
      check("R12 wake_any clear", {3'b0, wake_any}, 4'b0000);

      // R3: full 8-byte sequence on sleep
      for (int k = 0; k < 8; k++) wseq(2'd1, 3'(k), 8'(k + 1));
      match_len_m1 = {3'd0, 3'd7, 3'd2};
      for (int k = 0; k < 7; k++) send(8'(k + 1));
      check("R3 seven of eight bytes", wake_req, 4'b0000);
      send(8'h08);
      check("R3 eight-byte match", wake_req, 4'b0010);
      clear(4'hF);
      match_len_m1 = {3'd0, 3'd1, 3'd2};
      send(8'h01); send(8'h02);
      check("R3 shortened length matches", wake_req, 4'b0010);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule